// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master

This block runs short transactions with a serial peripheral over three pins: a serial clock, an active-high chip enable, and one data line shared by both directions. Each transaction starts with a command byte sent by the master. An 8-bit data phase follows. In a write the master also sends this byte. In a read the master releases the line and the peripheral drives it. Both bytes travel least significant bit first.

The host places a command byte, a write byte and a read/write flag on the inputs and pulses `start` for one cycle. `busy` stays high until the transaction ends. `done` then pulses for one cycle, and `rdata` carries the byte that was read. The serial clock rate comes from two parameters, the system clock frequency and the highest serial clock rate allowed. From these the block derives the number of system clocks in each serial half period. Setting the ceiling to 500 kHz or 2 MHz matches the low-voltage and high-voltage limits of such peripherals.

Top module: `tw_serial_master`

## Requirements
- R1: `ce` is high (asserted) from the cycle after an accepted `start` until the transaction ends. It is low whenever `busy` is low. `busy` is high from the cycle after an accepted `start` until the cycle in which `done` pulses.
- R2: `sclk` is low in every cycle in which `ce` is low.
- R3: Each serial half period lasts HALF_DIV system clocks, where HALF_DIV = ceil(SYS_HZ / (2*SCLK_MAX_HZ)) with a minimum of 2. Successive rising edges of `sclk` are therefore 2*HALF_DIV cycles apart. `ce` rises exactly HALF_DIV cycles before the first rising edge of `sclk`. `ce` falls at least HALF_DIV cycles after the last falling edge.
- R4: A transaction has exactly 16 rising edges of `sclk`. Rising edges 1 to 8 carry the command and rising edges 9 to 16 belong to the data byte.
- R5: Bytes move least significant bit first. Command bit k is on the line at rising edge k+1. Write-data bit k is on the line at rising edge k+9. Read-data bit k is the value the peripheral drives after the falling edge that follows rising edge k+8.
- R6: In a write, `sdo_oe` stays high while `ce` is high, and `sdo` never changes while `sclk` is high.
- R7: In a read, `sdo_oe` stays high through rising edge 8. It goes low before the falling edge that follows rising edge 8 and stays low for the rest of the transaction. The master samples each read bit during the clock-low interval after the peripheral updates it.
- R8: `sdo_oe` is low whenever `ce` is low.
- R9: A `start` pulse while `busy` is high is ignored. The running transaction keeps its command and data, and only one `done` pulse follows.
- R10: `done` is high for exactly one system clock, and `busy` is low in that cycle.
- R11: `rdata` changes only in the `done` cycle of a read. It holds its value through idle time and through write transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transaction |
| rw | input | 1 | 1 = read data phase, 0 = write data phase |
| cmd | input | 8 | Command byte, sent first |
| wdata | input | 8 | Data byte sent in a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| sclk | output | 1 | Serial clock, idles low |
| ce | output | 1 | Chip enable, active high |
| sdo | output | 1 | Data value driven onto the shared line |
| sdo_oe | output | 1 | Output enable for the shared line |
| sdi | input | 1 | Value sensed on the shared line |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `rw`, `cmd` and `wdata` are steady in the cycle `start` is accepted. They also assume that the peripheral drives the line only after a falling edge and only during the data phase of a read, so the line has a single owner at all times. The stimulus meets these assumptions in two ways. It drives all host inputs away from the clock edge and holds each one for a full cycle. The peripheral model in the bench turns its driver on only at the falling edges of a read's data phase, and off again at the final falling edge or when `ce` drops.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        TW_IDLE = 3'd0,
        TW_LEAD = 3'd1,
        TW_HIGH = 3'd2,
        TW_LOW  = 3'd3,
        TW_GAP  = 3'd4
    } tw_phase_e;

    typedef struct packed {
        logic              rd;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] wdata;
    } tw_req_t;

    // System clocks per serial half period, rounded up so the serial
    // rate never exceeds the ceiling; at least 2 so the turnaround fits.
    function automatic int half_period_div(input int sys_hz, input int sclk_hz);
        int q;
        q = (sys_hz + 2 * sclk_hz - 1) / (2 * sclk_hz);
        if (q < 2) q = 2;
        return q;
    endfunction

endpackage

// File: rtl/tw_tick_gen.sv
module tw_tick_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tw_seq.sv
module tw_seq
    import tw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      rd_in,
    input  logic      tick,
    output tw_phase_e phase,
    output logic      oe,
    output logic      rd_q,
    output logic      accept,
    output logic      shift_en,
    output logic      sample_en,
    output logic      finish,
    output logic      done
);
    localparam logic [IDX_W-1:0] LAST_CMD  = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_SAMP = IDX_W'(FRAME_BITS - 2);

    logic [IDX_W-1:0] idx;

    assign accept    = start && (phase == TW_IDLE);
    assign shift_en  = tick && (phase == TW_HIGH);
    assign sample_en = tick && (phase == TW_LOW) && rd_q &&
                       (idx >= LAST_CMD) && (idx <= LAST_SAMP);
    assign finish    = tick && (phase == TW_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= TW_IDLE;
            idx   <= '0;
            oe    <= 1'b0;
            rd_q  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= finish;
            case (phase)
                TW_IDLE: begin
                    if (start) begin
                        phase <= TW_LEAD;
                        idx   <= '0;
                        oe    <= 1'b1;
                        rd_q  <= rd_in;
                    end
                end
                TW_LEAD: begin
                    if (tick) phase <= TW_HIGH;
                end
                TW_HIGH: begin
                    // Turnaround: release the line one cycle after the
                    // last command bit has been clocked in.
                    if (rd_q && (idx == LAST_CMD)) oe <= 1'b0;
                    if (tick) phase <= TW_LOW;
                end
                TW_LOW: begin
                    if (tick) begin
                        if (idx == LAST_BIT) begin
                            phase <= TW_GAP;
                            oe    <= 1'b0;
                        end else begin
                            idx   <= idx + 1'b1;
                            phase <= TW_HIGH;
                        end
                    end
                end
                TW_GAP: begin
                    if (tick) phase <= TW_IDLE;
                end
                default: begin
                    phase <= TW_IDLE;
                    oe    <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/tw_datapath.sv
module tw_datapath
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  tw_req_t           req,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              finish,
    input  logic              rd_active,
    input  logic              line_in,
    output logic              line_out,
    output logic [BYTE_W-1:0] rdata
);
    logic [FRAME_BITS-1:0] tx;
    logic [BYTE_W-1:0]     rx;

    assign line_out = tx[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx    <= '0;
            rx    <= '0;
            rdata <= '0;
        end else begin
            if (accept) begin
                tx <= {req.wdata, req.cmd};
                rx <= '0;
            end else begin
                if (shift_en)  tx <= {1'b0, tx[FRAME_BITS-1:1]};
                if (sample_en) rx <= {line_in, rx[BYTE_W-1:1]};
            end
            if (finish && rd_active) rdata <= rx;
        end
    end
endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
    import tw_pkg::*;
#(
    parameter int SYS_HZ      = 250_000_000,
    parameter int SCLK_MAX_HZ = 2_000_000,
    parameter int HALF_DIV    = tw_pkg::half_period_div(SYS_HZ, SCLK_MAX_HZ)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       rw,
    input  logic [7:0] cmd,
    input  logic [7:0] wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rdata,
    output logic       sclk,
    output logic       ce,
    output logic       sdo,
    output logic       sdo_oe,
    input  logic       sdi
);
    tw_phase_e phase;
    tw_req_t   req;
    logic      tick, oe, rd_q, accept, shift_en, sample_en, finish;

    assign req = '{rd: rw, cmd: cmd, wdata: wdata};

    tw_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (phase != TW_IDLE),
        .tick (tick)
    );

    tw_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rd_in     (req.rd),
        .tick      (tick),
        .phase     (phase),
        .oe        (oe),
        .rd_q      (rd_q),
        .accept    (accept),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .finish    (finish),
        .done      (done)
    );

    tw_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req       (req),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .finish    (finish),
        .rd_active (rd_q),
        .line_in   (sdi),
        .line_out  (sdo),
        .rdata     (rdata)
    );

    assign busy   = (phase != TW_IDLE);
    assign sclk   = (phase == TW_HIGH);
    assign ce     = (phase == TW_LEAD) || (phase == TW_HIGH) || (phase == TW_LOW);
    assign sdo_oe = oe;
endmodule

// File: rtl/tw_serial_master_chk.sv
module tw_serial_master_chk #(
    parameter int HALF_DIV = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       rw,
    input logic       busy,
    input logic       done,
    input logic [7:0] rdata,
    input logic       sclk,
    input logic       ce,
    input logic       sdo,
    input logic       sdo_oe
);
    localparam int BW = 8;
    localparam int FB = 16;

    int   rises;
    int   low_run;
    logic sclk_q;
    logic rd_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            rises   <= 0;
            low_run <= 0;
            sclk_q  <= 1'b0;
            rd_mode <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (!ce) rises <= 0;
            else if (sclk && !sclk_q) rises <= rises + 1;
            if (sclk || !ce) low_run <= 0;
            else if (low_run < 1000000) low_run <= low_run + 1;
            if (start && !busy) rd_mode <= rw;
        end
    end

    AST_CE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) !busy |-> !ce); // R1
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !ce |-> !sclk); // R2
    AST_LEAD_TIME: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> (low_run >= HALF_DIV)); // R3
    AST_TRAIL_TIME: assert property (@(posedge clk) disable iff (rst) $fell(ce) |-> (low_run >= HALF_DIV)); // R3
    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (rst) $fell(ce) |-> (rises == FB)); // R4
    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst) (sclk && sdo_oe) |-> $stable(sdo)); // R6
    AST_WRITE_OE_HELD: assert property (@(posedge clk) disable iff (rst) (ce && !rd_mode && busy) |-> sdo_oe); // R6
    AST_CMD_OE_HELD: assert property (@(posedge clk) disable iff (rst) ($rose(sclk) && rises < BW) |-> sdo_oe); // R7
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst) ($fell(sclk) && rd_mode && rises >= BW) |-> !sdo_oe); // R7
    AST_OE_WITH_CE: assert property (@(posedge clk) disable iff (rst) !ce |-> !sdo_oe); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(rdata)); // R11
    AST_RDATA_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst) (done && !rd_mode) |-> $stable(rdata)); // R11
endmodule

bind tw_serial_master tw_serial_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .rw     (rw),
    .busy   (busy),
    .done   (done),
    .rdata  (rdata),
    .sclk   (sclk),
    .ce     (ce),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
);

// File: tb/sim_tw_serial_master.sv
`timescale 1ns/1ps
module sim_tw_serial_master;
    localparam int SYS  = 250_000_000;
    localparam int SCLK = 25_000_000;
    localparam int H    = (SYS + 2 * SCLK - 1) / (2 * SCLK);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rw = 1'b0;
    logic [7:0] cmd = '0;
    logic [7:0] wdata = '0;
    logic       busy, done, sclk, ce, sdo, sdo_oe;
    logic [7:0] rdata;
    logic       line;

    int nchk = 0;
    int nfail = 0;

    // Peripheral model state
    int         s_rises = 0;
    logic [7:0] s_cmd = '0;
    logic [7:0] s_wr = '0;
    logic [7:0] s_byte = '0;
    logic       s_rd = 1'b0;
    logic       s_oe = 1'b0;
    logic       s_bit = 1'b0;
    logic       oe_at_r8 = 1'b0;
    logic       oe_at_drive = 1'b1;

    // Monitor state
    int cyc = 0;
    int t_ce_rise = 0, t_last_rise = 0, t_last_fall = 0;
    int n_rise = 0, lead = 0, trail = 0, per_min = 0, per_max = 0;
    int contention = 0, wchg_bad = 0, idle_bad = 0, oe_drop_write = 0, done_cnt = 0;
    logic p_ce = 1'b0, p_sclk = 1'b0, p_sdo = 1'b0;

    always #2 clk = ~clk;

    assign line = s_oe ? s_bit : (sdo_oe ? sdo : 1'b1);

    tw_serial_master #(.SYS_HZ(SYS), .SCLK_MAX_HZ(SCLK)) u0 (
        .clk(clk), .rst(rst), .start(start), .rw(rw), .cmd(cmd), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata), .sclk(sclk), .ce(ce),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdi(line)
    );

    always @(posedge sclk) begin
        if (ce === 1'b1) begin
            if (s_rises == 7) oe_at_r8 = sdo_oe;
            if (s_rises < 8) s_cmd[s_rises[2:0]] = line;
            else if (!s_rd && s_rises < 16) s_wr[s_rises[2:0]] = line;
            s_rises = s_rises + 1;
        end
    end

    always @(negedge sclk) begin
        if (ce === 1'b1 && s_rd) begin
            if (s_rises >= 8 && s_rises <= 15) begin
                if (s_rises == 8) oe_at_drive = sdo_oe;
                s_oe  = 1'b1;
                s_bit = s_byte[s_rises[2:0]];
            end else if (s_rises >= 16) begin
                s_oe = 1'b0;
            end
        end
    end

    always @(negedge ce) s_oe = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (ce && !p_ce) t_ce_rise <= cyc;
            if (sclk && !p_sclk) begin
                if (n_rise == 0) lead <= cyc - t_ce_rise;
                else begin
                    if (per_min == 0 || cyc - t_last_rise < per_min) per_min <= cyc - t_last_rise;
                    if (cyc - t_last_rise > per_max) per_max <= cyc - t_last_rise;
                end
                t_last_rise <= cyc;
                n_rise <= n_rise + 1;
            end
            if (!sclk && p_sclk) t_last_fall <= cyc;
            if (!ce && p_ce) trail <= cyc - t_last_fall;
            if (s_oe && sdo_oe) contention <= contention + 1;
            if (sclk && p_sclk && sdo_oe && sdo != p_sdo) wchg_bad <= wchg_bad + 1;
            if (!ce && (sclk || sdo_oe)) idle_bad <= idle_bad + 1;
            if (ce && !s_rd && !sdo_oe) oe_drop_write <= oe_drop_write + 1;
            if (done) done_cnt <= done_cnt + 1;
        end
        p_ce <= ce; p_sclk <= sclk; p_sdo <= sdo;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lo);
        nchk++;
        if (act < lo) begin
            nfail++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lo);
        end
    endtask

    task automatic clear_mon();
        n_rise = 0; per_min = 0; per_max = 0; lead = 0; trail = 0;
        contention = 0; wchg_bad = 0; oe_drop_write = 0; done_cnt = 0;
        s_rises = 0; s_cmd = '0; s_wr = '0; oe_at_r8 = 1'b0; oe_at_drive = 1'b1;
    endtask

    // Runs one transaction; optional second start pulse while busy.
    task automatic txn(input logic rd, input logic [7:0] c, input logic [7:0] w,
                       input logic [7:0] sb, input bit intrude);
        logic [7:0] r_before;
        int t;
        bit seen;
        r_before = rdata;
        @(negedge clk);
        clear_mon();
        s_rd = rd; s_byte = sb;
        rw = rd; cmd = c; wdata = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", int'(busy), 1);
        chk("R1 ce after start", int'(ce), 1);
        if (intrude) begin
            repeat (6 * H) @(negedge clk);
            rw = ~rd; cmd = ~c; wdata = ~w; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 0;
        for (t = 0; t < 4000 && !seen; t++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk("R10 done seen", int'(seen), 1);
        chk("R10 busy low at done", int'(busy), 0);
        chk("R1 ce low at done", int'(ce), 0);
        @(negedge clk);
        chk("R10 done width", int'(done), 0);
        chk("R4 rising edges", s_rises, 16);
        chk("R5 command bits lsb first", int'(s_cmd), int'(c));
        chk("R3 lead", lead, H);
        chk_ge("R3 trail", trail, H);
        chk("R3 period min", per_min, 2 * H);
        chk("R3 period max", per_max, 2 * H);
        chk("R7 no contention", contention, 0);
        chk("R2 R8 idle pins", idle_bad, 0);
        if (rd) begin
            chk("R5 R7 read byte", int'(rdata), int'(sb));
            chk("R7 oe held at rise 8", int'(oe_at_r8), 1);
            chk("R7 oe released before drive", int'(oe_at_drive), 0);
        end else begin
            chk("R5 write bits lsb first", int'(s_wr), int'(w));
            chk("R6 sdo stable high", wchg_bad, 0);
            chk("R6 oe held in write", oe_drop_write, 0);
            chk("R11 rdata kept over write", int'(rdata), int'(r_before));
        end
        if (intrude) begin
            repeat (40 * H) @(negedge clk);
            chk("R9 single done", done_cnt, 1);
            chk("R9 stays idle", int'(busy), 0);
        end
    endtask

    task automatic reset_check();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset ce", int'(ce), 0);
        chk("R2 reset sclk", int'(sclk), 0);
        chk("R8 reset oe", int'(sdo_oe), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R11 reset rdata", int'(rdata), 0);
    endtask

    task automatic idle_hold_check();
        logic [7:0] r0;
        r0 = rdata;
        repeat (25) @(negedge clk);
        chk("R11 rdata idle hold", int'(rdata), int'(r0));
        chk("R2 R8 idle pins", idle_bad, 0);
    endtask

    initial begin
        reset_check();
        txn(1'b0, 8'h80, 8'hA5, 8'h00, 1'b0);
        txn(1'b0, 8'h01, 8'h3C, 8'h00, 1'b0);
        txn(1'b1, 8'h81, 8'h00, 8'h96, 1'b0);
        idle_hold_check();
        txn(1'b0, 8'hFE, 8'h01, 8'h00, 1'b0);
        txn(1'b1, 8'h83, 8'hFF, 8'h01, 1'b0);
        txn(1'b1, 8'hC1, 8'h00, 8'h80, 1'b0);
        txn(1'b0, 8'h8E, 8'h5A, 8'h00, 1'b1);
        txn(1'b1, 8'hBF, 8'h00, 8'h4D, 1'b1);
        idle_hold_check();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule